// File: doc/BRIEF.md
# DMA Completion Interrupt Collector

This block gathers transfer-progress events from sixteen DMA channels and folds them into a single interrupt request. The channels come in two groups of eight, a normal group and a dedicated group. Each channel reports two kinds of one-cycle event pulse: a half-way event and an end-of-transfer event. Every pulse is latched into a sticky pending bit. Software owns a 32-bit enable mask and clears pending bits by writing ones to them. The interrupt line is high while any pending bit is also enabled.

Each channel owns two adjacent bits of the 32-bit pending word. The even bit holds its half-way event and the odd bit holds its end event. The normal group fills bits 15..0 and the dedicated group fills bits 31..16. Handler software can therefore pick out all end events with the mask 0xAAAAAAAA, and it can find the channel that owns any bit from that bit's position alone.

The register port is a plain single-cycle access port with no stall. A write takes effect at the clock edge where it is presented. A read returns data combinationally from the current register state.

Top module: `dma_irq_collector`

## Requirements
- R1: After reset, the enable register, the pending register and `irq_o` are all zero.
- R2: An end pulse on channel c (0..7) of group g (0 normal, 1 dedicated) sets pending bit g*16 + 2*c + 1 at the next clock edge. A half-way pulse sets bit g*16 + 2*c. No other bit changes because of that pulse.
- R3: A pending bit is set by its event whether or not its enable bit is set.
- R4: A write (`bus_sel`=1, `bus_wr`=1) to offset 0x04 clears exactly the pending bits that are 1 in `bus_wdata` and leaves all other pending bits unchanged. Writing 0xFFFFFFFF clears every pending bit.
- R5: If an event and a clearing write hit the same pending bit in the same cycle, the bit is set after that edge.
- R6: A write to offset 0x00 loads `bus_wdata` into the enable register.
- R7: `irq_o` is 1 exactly when some bit is 1 in both the pending and enable registers, and it follows the registers without extra delay.
- R8: A read (`bus_sel`=1, `bus_wr`=0) returns the enable register at offset 0x00 and the pending register at offset 0x04. It returns zero at any other offset and whenever no read is presented. A write to any other offset changes no register.
- R9: With the enable register at zero, `irq_o` stays low however many pending bits are set, and the pending bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| nrm_half_evt | input | 8 | Half-way pulses, normal group, bit c for channel c |
| nrm_end_evt | input | 8 | End pulses, normal group |
| ded_half_evt | input | 8 | Half-way pulses, dedicated group |
| ded_end_evt | input | 8 | End pulses, dedicated group |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a collision, where a new event arrives on a bit in the same clock cycle that software writes a one to clear that bit. The bench reaches it by driving an event pulse and a pending-register write in the same low clock phase, so both are sampled at one edge. It then reads the bit back. A long random phase mixes event bursts with clears, enable writes and reads to mapped and unmapped offsets. A behavioural model checks the interrupt line at every clock and checks every read.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned GROUPS      = 2;
  localparam int unsigned CH_PER_GRP  = 8;
  localparam int unsigned SLOTS_PER_CH = 2;
  localparam int unsigned REG_W       = GROUPS * CH_PER_GRP * SLOTS_PER_CH;
  localparam int unsigned ADDR_W      = 8;

  localparam logic [ADDR_W-1:0] OFF_ENABLE  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PENDING = 8'h04;

  typedef enum logic [0:0] {
    SLOT_HALF = 1'b0,
    SLOT_END  = 1'b1
  } slot_e;

  function automatic int unsigned slot_bit(int unsigned grp, int unsigned ch, slot_e kind);
    return grp * CH_PER_GRP * SLOTS_PER_CH + ch * SLOTS_PER_CH + int'(kind);
  endfunction
endpackage

// File: rtl/dma_irq_evt_map.sv
module dma_irq_evt_map
  import dma_irq_pkg::*;
#(
  parameter int unsigned NGRP = GROUPS,
  parameter int unsigned NCH  = CH_PER_GRP,
  localparam int unsigned NSRC = NGRP * NCH,
  localparam int unsigned VW   = NSRC * SLOTS_PER_CH
) (
  input  logic [NSRC-1:0] half_evt,
  input  logic [NSRC-1:0] end_evt,
  output logic [VW-1:0]   evt_vec
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int unsigned SRC = g * NCH + c;
      assign evt_vec[slot_bit(g, c, SLOT_HALF)] = half_evt[SRC];
      assign evt_vec[slot_bit(g, c, SLOT_END)]  = end_evt[SRC];
    end
  end
endmodule

// File: rtl/dma_irq_bus_dec.sv
module dma_irq_bus_dec
  import dma_irq_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = REG_W
) (
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] en_q,
  input  logic [DW-1:0] pend_q,
  output logic          en_we,
  output logic [DW-1:0] clr_mask,
  output logic [DW-1:0] bus_rdata
);
  logic hit_en, hit_pend, do_wr, do_rd;

  always_comb begin
    hit_en   = (bus_addr == AW'(OFF_ENABLE));
    hit_pend = (bus_addr == AW'(OFF_PENDING));
    do_wr    = bus_sel && bus_wr;
    do_rd    = bus_sel && !bus_wr;
    en_we    = do_wr && hit_en;
    clr_mask = (do_wr && hit_pend) ? bus_wdata : '0;
    bus_rdata = '0;
    if (do_rd && hit_en)   bus_rdata = en_q;
    if (do_rd && hit_pend) bus_rdata = pend_q;
  end
endmodule

// File: rtl/dma_irq_pend_bank.sv
module dma_irq_pend_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pend_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pend_q[i] <= 1'b0;
      else if (evt[i])      pend_q[i] <= 1'b1;
      else if (clr_mask[i]) pend_q[i] <= 1'b0;
    end
  end

  AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend_q & $past(evt)) == $past(evt))); // R5
  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(pend_q) & ~pend_q) & ~$past(clr_mask)) == '0)); // R4
  AST_RISE_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend_q & ~$past(pend_q)) & ~$past(evt)) == '0)); // R2
endmodule

// File: rtl/dma_irq_collector.sv
module dma_irq_collector
  import dma_irq_pkg::*;
#(
  parameter int unsigned NGRP = GROUPS,
  parameter int unsigned NCH  = CH_PER_GRP,
  parameter int unsigned AW   = ADDR_W,
  localparam int unsigned DW  = NGRP * NCH * SLOTS_PER_CH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NCH-1:0] nrm_half_evt,
  input  logic [NCH-1:0] nrm_end_evt,
  input  logic [NCH-1:0] ded_half_evt,
  input  logic [NCH-1:0] ded_end_evt,
  output logic          irq_o
);
  logic [NGRP*NCH-1:0] half_all, end_all;
  logic [DW-1:0] evt_vec, pend_q, en_q, clr_mask;
  logic en_we;

  assign half_all = {ded_half_evt, nrm_half_evt};
  assign end_all  = {ded_end_evt, nrm_end_evt};

  dma_irq_evt_map #(.NGRP(NGRP), .NCH(NCH)) u_map (
    .half_evt(half_all), .end_evt(end_all), .evt_vec(evt_vec)
  );

  dma_irq_bus_dec #(.AW(AW), .DW(DW)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_q(en_q), .pend_q(pend_q),
    .en_we(en_we), .clr_mask(clr_mask), .bus_rdata(bus_rdata)
  );

  dma_irq_pend_bank #(.W(DW)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr_mask(clr_mask), .pend_q(pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= bus_wdata;
  end

  assign irq_o = |(pend_q & en_q);

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(OFF_ENABLE)) |=> (en_q == $past(bus_wdata))); // R6
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == AW'(OFF_ENABLE)) |=> $stable(en_q)); // R8
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o); // R9
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_q != '0)); // R7
endmodule

// File: tb/tb_dma_irq_collector.sv
`timescale 1ns/1ps
module tb_dma_irq_collector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0] nh = '0, ne = '0, dh = '0, de = '0;
  logic irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural reference state
  logic [31:0] m_en = '0, m_pend = '0;

  always #2.5 clk = ~clk;

  dma_irq_collector dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nrm_half_evt(nh), .nrm_end_evt(ne), .ded_half_evt(dh), .ded_end_evt(de),
    .irq_o(irq_o)
  );

  function automatic logic [31:0] events(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic [7:0] d);
    logic [31:0] v = '0;
    for (int ch = 0; ch < 8; ch++) begin
      if (a[ch]) v[ch*2]          = 1'b1;
      if (b[ch]) v[ch*2 + 1]      = 1'b1;
      if (c[ch]) v[16 + ch*2]     = 1'b1;
      if (d[ch]) v[16 + ch*2 + 1] = 1'b1;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_pend = '0;
    end else begin
      logic [31:0] clr;
      clr = (bus_sel && bus_wr && bus_addr == 8'h04) ? bus_wdata : '0;
      m_pend = (m_pend & ~clr) | events(nh, ne, dh, de);
      if (bus_sel && bus_wr && bus_addr == 8'h00) m_en = bus_wdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R7: compare interrupt line against the model every cycle
  always @(negedge clk) if (rst_n && !done) chk("R7 irq", {31'b0, irq_o}, {31'b0, |(m_pend & m_en)});

  task automatic idle();
    bus_sel = 0; bus_wr = 0; nh = '0; ne = '0; dh = '0; de = '0;
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(); idle(); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc(); idle();
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    cyc(); idle(); bus_sel = 1; bus_wr = 0; bus_addr = a; bus_wdata = $urandom;
    #1 chk(tag, bus_rdata, exp);
    cyc(); idle();
  endtask

  task automatic pulse(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic [7:0] d);
    cyc(); idle(); nh = a; ne = b; dh = c; de = d;
    cyc(); idle();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(8'h00, 32'h0, "R1 enable");
    rd(8'h04, 32'h0, "R1 pending");
    // R2/R3: end event on normal ch3 while masked
    pulse(8'h00, 8'h08, 8'h00, 8'h00);
    rd(8'h04, 32'h0000_0080, "R2 R3 end bit normal ch3");
    chk("R3 masked irq", {31'b0, irq_o}, 32'h0);
    // R2: half event on dedicated ch5 -> bit 26
    pulse(8'h00, 8'h00, 8'h20, 8'h00);
    rd(8'h04, 32'h0400_0080, "R2 half bit dedicated ch5");
    // R6 enable load and read
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'hFFFF_FFFF, "R6 enable readback");
    chk("R7 irq raised", {31'b0, irq_o}, 32'h1);
    // R4 partial clear
    wr(8'h04, 32'h0000_0080);
    rd(8'h04, 32'h0400_0000, "R4 partial clear");
    // R9 mask all
    wr(8'h00, 32'h0);
    chk("R9 irq masked", {31'b0, irq_o}, 32'h0);
    rd(8'h04, 32'h0400_0000, "R9 pending kept");
    // R5 collision on bit 31
    cyc(); idle(); de = 8'h80; bus_sel = 1; bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'h8000_0000;
    cyc(); idle();
    rd(8'h04, 32'h8400_0000, "R5 set wins over clear");
    // R4 clear all
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0, "R4 clear all");
    // R8 unmapped
    pulse(8'h01, 8'h00, 8'h00, 8'h00);
    wr(8'h00, 32'h0000_0001);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_0001, "R8 unmapped write leaves enable");
    rd(8'h04, 32'h0000_0001, "R8 unmapped write leaves pending");
    rd(8'h08, 32'h0, "R8 unmapped read zero");
    cyc(); idle(); bus_sel = 0; bus_addr = 8'h04; #1 chk("R8 no read zero", bus_rdata, 32'h0);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      cyc(); idle();
      if ($urandom_range(0, 2) == 0) begin
        nh = 8'($urandom); ne = 8'($urandom); dh = 8'($urandom); de = 8'($urandom);
      end
      case ($urandom_range(0, 3))
        0: begin bus_sel = 1; bus_wr = 1; bus_addr = 8'h04; bus_wdata = $urandom; end
        1: begin bus_sel = 1; bus_wr = 1; bus_addr = ($urandom_range(0, 3) == 0) ? 8'h0C : 8'h00; bus_wdata = $urandom; end
        2: begin
          bus_sel = 1; bus_wr = 0; bus_addr = 8'($urandom_range(0, 2) * 4);
          #1 chk("R8 random read", bus_rdata,
                 bus_addr == 8'h00 ? m_en : (bus_addr == 8'h04 ? m_pend : 32'h0));
        end
        default: ;
      endcase
    end
    cyc(); idle(); cyc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule